// File: doc/BRIEF.md
# Bootstrap Memory Copy Engine

This block keeps a short boot program in a small scratch SRAM that stays powered through sleep. On request it copies a run of dwords from that SRAM into a processor's instruction SRAM. Software talks to it through a 32-bit register interface. Through that interface it loads the scratch SRAM, programs the source, destination and length of the copy, and starts it.

A copy starts in one of two ways. Software can write the launch bit, which then reads back as 1 until the copy ends. Alternatively, software can set the arm bit. While the block is armed, every power-up pulse repeats the same programmed copy without software involvement. Each dword takes one cycle to read from the scratch SRAM and one cycle to write into the instruction SRAM. A done flag records that the last copy completed.

Top module: `bootcopy_engine`

## Requirements
- R1: After reset the control word (offset 0x000) and the status word (offset 0x010) read 0, and `iram_we` stays low.
- R2: Software reads and writes the scratch SRAM with dword accesses in the window 0x400 to 0x7FF. Word k sits at byte offset 0x400 + 4k. Every bus read returns its data in `bus_rdata` one cycle after the request.
- R3: The source address (0x004), destination address (0x008) and dword count (0x00C) read back as last written.
- R4: Writing the control word with bit 31 set starts a copy when the block is idle. Bit 31 reads 1 while the copy runs and 0 once it has ended.
- R5: Each dword uses one scratch read cycle followed by one cycle with `iram_we` high. The k-th write (counting from 0) goes to destination + 4k and carries scratch word (source/4 + k) modulo the scratch depth.
- R6: A copy started with a count of 0 sets done on the next cycle without any instruction SRAM write, and bit 31 never reads 1.
- R7: A launch write arriving while a copy runs is ignored, and so is a `pwr_up` pulse arriving while a copy runs. The running copy is not lengthened and not restarted.
- R8: Control bit 30 arms the block. While armed and idle, a one-cycle `pwr_up` pulse starts the programmed copy.
- R9: Writing the control word with bits 31 and 30 both 0 disarms the block. A later `pwr_up` pulse then causes no write.
- R10: Status bit 0 reads 1 after a copy has completed. It returns to 0 in the cycle after a non-empty copy starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register or window access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pwr_up | input | 1 | Power-up event pulse |
| iram_we | output | 1 | Instruction SRAM write strobe |
| iram_addr | output | 32 | Instruction SRAM byte address |
| iram_wdata | output | 32 | Instruction SRAM write data |

## Verification
The bound assertions check several rules on every cycle:
- write strobes never fall on adjacent cycles;
- each write follows a scratch read;
- the write address steps by 4 within a copy;
- done clears when a copy starts and holds when one ends;
- an empty copy finishes at once.

Some behaviours only the bench scenarios can show: that the written data is the right scratch word, including wrap at the top of the SRAM; that triggers arriving during a copy are dropped; and that disarming stops power-up replays. The bench shows these by comparing against its own cycle model and by counting writes per copy.

// File: rtl/bootcopy_pkg.sv
package bootcopy_pkg;

  typedef enum logic [1:0] {
    CP_IDLE  = 2'd0,
    CP_READ  = 2'd1,
    CP_WRITE = 2'd2
  } cp_state_t;

  localparam int OFS_CTRL   = 'h000;
  localparam int OFS_SRC    = 'h004;
  localparam int OFS_DST    = 'h008;
  localparam int OFS_COUNT  = 'h00C;
  localparam int OFS_STATUS = 'h010;

  localparam int CTRL_LAUNCH_BIT = 31;
  localparam int CTRL_ARM_BIT    = 30;

  // byte address of the next dword
  function automatic logic [31:0] step_addr(input logic [31:0] a);
    return a + 32'd4;
  endfunction

  // control word as seen by software
  function automatic logic [31:0] ctrl_word(input logic running, input logic armed);
    return {running, armed, 30'd0};
  endfunction

endpackage

// File: rtl/bootcopy_scratch.sv
module bootcopy_scratch #(
  parameter int WORDS = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_idx,
  output logic [31:0]      a_q,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  output logic [31:0]      b_q
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (a_en)  a_q <= mem[a_idx];
    if (b_en)  b_q <= mem[b_idx];
  end

endmodule

// File: rtl/bootcopy_regs.sv
module bootcopy_regs
  import bootcopy_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SCR_WORDS = 256,
  parameter int WIN_BASE  = 'h400,   // must be aligned to the window size
  localparam int IDX_W    = $clog2(SCR_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [31:0]       scr_q,
  output logic              scr_rd_en,
  output logic              scr_wr_en,
  output logic [IDX_W-1:0]  scr_idx,
  output logic [31:0]       src_q,
  output logic [31:0]       dst_q,
  output logic [31:0]       cnt_q,
  output logic              arm_q,
  output logic              sw_start
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SRC    = ADDR_W'(OFS_SRC);
  localparam logic [ADDR_W-1:0] A_DST    = ADDR_W'(OFS_DST);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] WIN_LO   = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI   = ADDR_W'(WIN_BASE + SCR_WORDS * 4 - 1);

  logic in_win, rd_req, wr_req, ctrl_wr;
  logic [31:0] rd_mux, reg_rd_q;
  logic from_scr_q;

  assign in_win    = (bus_addr >= WIN_LO) && (bus_addr <= WIN_HI);
  assign rd_req    = bus_sel && !bus_we;
  assign wr_req    = bus_sel && bus_we;
  assign ctrl_wr   = wr_req && (bus_addr == A_CTRL);
  assign sw_start  = ctrl_wr && bus_wdata[CTRL_LAUNCH_BIT];
  assign scr_idx   = bus_addr[IDX_W+1:2];
  assign scr_rd_en = rd_req && in_win;
  assign scr_wr_en = wr_req && in_win;

  always_comb begin
    case (bus_addr)
      A_CTRL:   rd_mux = ctrl_word(busy, arm_q);
      A_SRC:    rd_mux = src_q;
      A_DST:    rd_mux = dst_q;
      A_COUNT:  rd_mux = cnt_q;
      A_STATUS: rd_mux = {31'd0, done};
      default:  rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= 32'd0;
      dst_q      <= 32'd0;
      cnt_q      <= 32'd0;
      arm_q      <= 1'b0;
      reg_rd_q   <= 32'd0;
      from_scr_q <= 1'b0;
    end else begin
      if (wr_req && bus_addr == A_SRC)   src_q <= bus_wdata;
      if (wr_req && bus_addr == A_DST)   dst_q <= bus_wdata;
      if (wr_req && bus_addr == A_COUNT) cnt_q <= bus_wdata;
      if (ctrl_wr)                       arm_q <= bus_wdata[CTRL_ARM_BIT];
      if (rd_req) begin
        from_scr_q <= in_win;
        reg_rd_q   <= rd_mux;
      end
    end
  end

  assign bus_rdata = from_scr_q ? scr_q : reg_rd_q;

endmodule

// File: rtl/bootcopy_seq.sv
module bootcopy_seq
  import bootcopy_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             pwr_up,
  input  logic             arm,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [31:0]      dst,
  input  logic [31:0]      cnt,
  input  logic [31:0]      rd_data,
  output logic             rd_phase,
  output logic [IDX_W-1:0] rd_idx,
  output logic             iram_we,
  output logic [31:0]      iram_addr,
  output logic [31:0]      iram_wdata,
  output logic             busy,
  output logic             done,
  output logic             launch,
  output logic             cnt_zero
);

  cp_state_t        state;
  logic [31:0]      remain;
  logic [IDX_W-1:0] sidx;
  logic [31:0]      dptr;

  assign busy       = (state != CP_IDLE);
  assign launch     = !busy && (sw_start || (arm && pwr_up));
  assign cnt_zero   = (cnt == 32'd0);
  assign rd_phase   = (state == CP_READ);
  assign rd_idx     = sidx;
  assign iram_we    = (state == CP_WRITE);
  assign iram_addr  = dptr;
  assign iram_wdata = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= CP_IDLE;
      done   <= 1'b0;
      remain <= 32'd0;
      sidx   <= '0;
      dptr   <= 32'd0;
    end else begin
      case (state)
        CP_IDLE: if (launch) begin
          if (cnt_zero) begin
            done <= 1'b1;
          end else begin
            done   <= 1'b0;
            state  <= CP_READ;
            remain <= cnt;
            sidx   <= src_idx;
            dptr   <= dst;
          end
        end
        CP_READ: state <= CP_WRITE;
        CP_WRITE: begin
          sidx   <= sidx + IDX_W'(1);
          dptr   <= step_addr(dptr);
          remain <= remain - 32'd1;
          if (remain == 32'd1) begin
            state <= CP_IDLE;
            done  <= 1'b1;
          end else begin
            state <= CP_READ;
          end
        end
        default: state <= CP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bootcopy_engine.sv
module bootcopy_engine #(
  parameter int ADDR_W    = 12,
  parameter int SCR_WORDS = 256,
  parameter int WIN_BASE  = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pwr_up,
  output logic              iram_we,
  output logic [31:0]       iram_addr,
  output logic [31:0]       iram_wdata
);

  localparam int IDX_W = $clog2(SCR_WORDS);

  logic             busy, done, launch, cnt_zero, rd_phase;
  logic             sw_start, arm_q;
  logic [31:0]      src_q, dst_q, cnt_q;
  logic             bus_scr_rd, bus_scr_wr;
  logic [IDX_W-1:0] bus_scr_idx, cp_idx;
  logic [31:0]      bus_scr_q, cp_q;

  bootcopy_regs #(
    .ADDR_W(ADDR_W), .SCR_WORDS(SCR_WORDS), .WIN_BASE(WIN_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .scr_q(bus_scr_q),
    .scr_rd_en(bus_scr_rd), .scr_wr_en(bus_scr_wr), .scr_idx(bus_scr_idx),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .arm_q(arm_q),
    .sw_start(sw_start)
  );

  bootcopy_scratch #(.WORDS(SCR_WORDS)) u_scratch (
    .clk(clk),
    .wr_en(bus_scr_wr), .wr_idx(bus_scr_idx), .wr_data(bus_wdata),
    .a_en(bus_scr_rd), .a_idx(bus_scr_idx), .a_q(bus_scr_q),
    .b_en(rd_phase), .b_idx(cp_idx), .b_q(cp_q)
  );

  bootcopy_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sw_start(sw_start), .pwr_up(pwr_up), .arm(arm_q),
    .src_idx(src_q[IDX_W+1:2]), .dst(dst_q), .cnt(cnt_q),
    .rd_data(cp_q), .rd_phase(rd_phase), .rd_idx(cp_idx),
    .iram_we(iram_we), .iram_addr(iram_addr), .iram_wdata(iram_wdata),
    .busy(busy), .done(done), .launch(launch), .cnt_zero(cnt_zero)
  );

endmodule

// File: rtl/bootcopy_checker.sv
module bootcopy_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        iram_we,
  input logic [31:0] iram_addr,
  input logic        busy,
  input logic        done,
  input logic        launch,
  input logic        cnt_zero,
  input logic        rd_phase
);

  // R5: a write cycle never directly follows another
  p_we_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iram_we |=> !iram_we);

  // R5: every write is preceded by a scratch read cycle
  p_read_before_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iram_we |-> $past(rd_phase));

  // R5: destination advances by one dword per word
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iram_we && $past(iram_we, 2)) |-> (iram_addr == $past(iram_addr, 2) + 32'd4));

  // R4: running only ever begins from a launch
  p_busy_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));

  // R10: done clears when a non-empty copy starts
  p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !cnt_zero) |=> (busy && !done));

  // R10: done is set when a copy ends
  p_done_on_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6: an empty copy completes at once without writes
  p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cnt_zero) |=> (done && !busy && !iram_we));

endmodule

bind bootcopy_engine bootcopy_checker u_chk (
  .clk(clk), .rst_n(rst_n), .iram_we(iram_we), .iram_addr(iram_addr),
  .busy(busy), .done(done), .launch(launch), .cnt_zero(cnt_zero),
  .rd_phase(rd_phase)
);

// File: tb/bootcopy_engine_test.sv
module bootcopy_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwr_up = 1'b0;
  logic        iram_we;
  logic [31:0] iram_addr, iram_wdata;

  int total = 0;
  int bad   = 0;
  int wr_seen = 0;

  bootcopy_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_up(pwr_up), .iram_we(iram_we), .iram_addr(iram_addr),
    .iram_wdata(iram_wdata)
  );

  always #10 clk = ~clk;   // 50 MHz

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_scr [256];
  int          m_phase = 0;      // 0 idle, 1 reading, 2 writing
  logic [31:0] m_src = 0, m_dst = 0, m_cnt = 0;
  logic [31:0] m_sptr = 0, m_dptr = 0, m_left = 0;
  bit          m_arm = 0, m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_src = 0; m_dst = 0; m_cnt = 0;
      m_arm = 0; m_done = 0; m_left = 0;
    end else begin
      bit go;
      go = (m_phase == 0) &&
           ((bus_sel && bus_we && bus_addr == 12'h000 && bus_wdata[31]) ||
            (m_arm && pwr_up));
      if (m_phase == 1) m_phase = 2;
      else if (m_phase == 2) begin
        m_sptr = m_sptr + 4; m_dptr = m_dptr + 4; m_left = m_left - 1;
        if (m_left == 0) begin m_phase = 0; m_done = 1; end
        else m_phase = 1;
      end else if (go) begin
        if (m_cnt == 0) m_done = 1;
        else begin
          m_done = 0; m_phase = 1;
          m_sptr = m_src; m_dptr = m_dst; m_left = m_cnt;
        end
      end
      if (bus_sel && bus_we) begin
        case (bus_addr)
          12'h000: m_arm = bus_wdata[30];
          12'h004: m_src = bus_wdata;
          12'h008: m_dst = bus_wdata;
          12'h00C: m_cnt = bus_wdata;
          default: if (bus_addr >= 12'h400)
                     m_scr[(bus_addr - 12'h400) >> 2] = bus_wdata;
        endcase
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    if (a >= 12'h400) return m_scr[(a - 12'h400) >> 2];
    case (a)
      12'h000: return {m_phase != 0, m_arm, 30'd0};
      12'h004: return m_src;
      12'h008: return m_dst;
      12'h00C: return m_cnt;
      12'h010: return {31'd0, m_done};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input bit ok,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison of the instruction SRAM port (R5)
  always @(negedge clk) begin
    if (rst_n) begin
      if (iram_we) wr_seen++;
      check("R5 we", iram_we === (m_phase == 2), {31'd0, iram_we},
            {31'd0, m_phase == 2});
      if (m_phase == 2) begin
        check("R5 addr", iram_addr === m_dptr, iram_addr, m_dptr);
        check("R5 data", iram_wdata === m_scr[(m_sptr >> 2) % 256],
              iram_wdata, m_scr[(m_sptr >> 2) % 256]);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, input string req,
                          output logic [31:0] v);
    logic [31:0] exp;
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    exp = model_read(a);
    @(negedge clk);
    bus_sel = 0;
    v = bus_rdata;
    check(req, v === exp, v, exp);
  endtask

  task automatic pulse_pwr;
    @(negedge clk); pwr_up = 1;
    @(negedge clk); pwr_up = 0;
  endtask

  task automatic wait_idle;
    logic [31:0] v;
    for (int k = 0; k < 60; k++) begin
      bus_read(12'h000, "R4 poll", v);
      if (!v[31]) break;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    bus_read(12'h000, "R1 ctrl", v);   check("R1 ctrl zero", v == 0, v, 0);
    bus_read(12'h010, "R1 status", v); check("R1 status zero", v == 0, v, 0);
    check("R1 no write", iram_we === 1'b0, {31'd0, iram_we}, 0);

    // R2: scratch window
    for (int i = 0; i < 16; i++)
      bus_write(12'h400 + 12'(4 * i), 32'hC0DE0000 + 32'(i * 'h111));
    bus_write(12'h7F8, 32'h5A5A_00FE);
    bus_write(12'h7FC, 32'h5A5A_00FF);
    bus_read(12'h404, "R2 word1", v);
    check("R2 word1 lit", v == 32'hC0DE0111, v, 32'hC0DE0111);
    bus_read(12'h7FC, "R2 last", v);

    // R3: address/count registers
    bus_write(12'h004, 32'h0);
    bus_write(12'h008, 32'h0000_1000);
    bus_write(12'h00C, 32'd4);
    bus_read(12'h004, "R3 src", v);
    bus_read(12'h008, "R3 dst", v);
    bus_read(12'h00C, "R3 count", v);

    // R4/R5/R10: software launch
    base = wr_seen;
    bus_write(12'h000, 32'h8000_0000);
    bus_read(12'h000, "R4 running", v);
    check("R4 bit31 high", v[31] == 1'b1, v, 32'h8000_0000);
    wait_idle();
    bus_read(12'h010, "R10 done", v);
    check("R10 done set", v == 1, v, 1);
    check("R5 four writes", wr_seen - base == 4, wr_seen - base, 4);

    // R10 clear + R7 relaunch ignored
    base = wr_seen;
    bus_write(12'h000, 32'h8000_0000);
    bus_read(12'h010, "R10 cleared", v);
    check("R10 done clear", v == 0, v, 0);
    bus_write(12'h000, 32'h8000_0000);
    wait_idle();
    check("R7 no extra writes", wr_seen - base == 4, wr_seen - base, 4);

    // R6: zero count
    bus_write(12'h00C, 32'd0);
    base = wr_seen;
    bus_write(12'h000, 32'h8000_0000);
    bus_read(12'h000, "R6 ctrl", v);
    check("R6 bit31 low", v == 0, v, 0);
    bus_read(12'h010, "R6 status", v);
    check("R6 done", v == 1, v, 1);
    check("R6 no writes", wr_seen - base == 0, wr_seen - base, 0);

    // R8: armed power-up replay with wrap, R7 pulse during copy ignored
    bus_write(12'h004, 32'h0000_03F8);
    bus_write(12'h008, 32'h0000_2000);
    bus_write(12'h00C, 32'd3);
    bus_write(12'h000, 32'h4000_0000);
    bus_read(12'h000, "R8 armed", v);
    check("R8 arm bit", v == 32'h4000_0000, v, 32'h4000_0000);
    base = wr_seen;
    pulse_pwr();
    pulse_pwr();
    wait_idle();
    check("R8 replay writes", wr_seen - base == 3, wr_seen - base, 3);
    bus_read(12'h010, "R8 done", v);

    // R9: disarm
    bus_write(12'h000, 32'h0);
    base = wr_seen;
    pulse_pwr();
    repeat (10) @(negedge clk);
    check("R9 no writes", wr_seen - base == 0, wr_seen - base, 0);
    bus_read(12'h000, "R9 ctrl", v);
    check("R9 ctrl zero", v == 0, v, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule